// File: doc/BRIEF.md
# LCD Phase and Frame Timer

This block turns a slow LCD input clock into the time base that sequences a multiplexed segment display. The input clock passes through two dividers in series: a coarse power-of-two stage selected by a 4-bit exponent, and a fine linear stage that divides by 16 to 31. Together they set the length of one drive phase. The block marks the end of each phase with a one-cycle enable pulse. That pulse is not a derived clock, so everything downstream stays in the input clock domain.

The block counts phases into frames. The number of phases per frame is the number of active common lines, from 1 to 8. The block reports the current phase index, a start-of-frame pulse and an odd/even frame flag. Downstream logic uses the flag to alternate drive polarity, so the display sees no net DC. Settings that change mid-frame are held off until the current frame ends. A frame is therefore never shortened or stretched by a reconfiguration.

Top module: `lcd_phase_timer`

## Requirements
- R1: After reset, phaseTick, frameStart and oddFrame are 0 and phaseIdx is 0.
- R2: While enable is 1, phaseTick is a one-cycle pulse every 2^preScale × (16 + fineDiv) input clock cycles. The first pulse is high in the cycle that follows the N-th rising edge at which enable is sampled 1, where N is that period.
- R3: fineDiv (4 bits) adds linearly to a base of 16, giving fine ratios of 16 to 31. preScale (4 bits, 0 to 15) multiplies the period by 2^preScale.
- R4: The active common count D equals dutySel + 1 (dutySel 3 bits, so D is 1 to 8). phaseIdx advances by one only in the cycle phaseTick is high, and it already shows the new value in that cycle. After D−1 it returns to 0.
- R5: frameStart is high exactly in the cycles where phaseTick is high and phaseIdx has just returned to 0.
- R6: oddFrame inverts in every cycle in which frameStart is high and holds its value otherwise. A low enable does not change it.
- R7: While enable is 1, new values on preScale, fineDiv and dutySel take effect only at a frame boundary, that is, on the tick that asserts frameStart. The frame in progress keeps its old phase length and phase count.
- R8: While enable is 0, the block emits no phaseTick and no frameStart and holds phaseIdx at 0. It also takes its settings directly from the inputs, so the first period after enable rises uses the values present then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the dividers; low clears them |
| preScale | input | 4 | Coarse exponent, divide by 2^preScale |
| fineDiv | input | 4 | Fine divide is 16 + fineDiv |
| dutySel | input | 3 | Active commons minus one |
| phaseTick | output | 1 | One-cycle pulse at each phase end |
| phaseIdx | output | 3 | Current phase within the frame |
| frameStart | output | 1 | Pulse with the tick that begins a frame |
| oddFrame | output | 1 | Frame parity, inverts every frame |

## Verification
A coarse or fine counter that slips moves every later tick, and the bench compares every cycle. One miscount is therefore seen at the very next expected tick, at most one phase period later. A phase counter with the wrong wrap point shows up within one frame, as a phaseIdx beyond D−1 or as a missing or extra frameStart. A parity or reload fault shows up at the following frame start, as a wrong oddFrame value or a frame length that does not match the settings latched at the boundary.

// File: rtl/lcd_phase_pkg.sv
package lcd_phase_pkg;
  localparam int PS_W      = 4;
  localparam int DIV_W     = 4;
  localparam int DUTY_W    = 3;
  localparam int FINE_BASE = 16;

  typedef struct packed {
    logic run;    // advance the dividers this cycle
    logic clear;  // return both dividers to zero
  } divCtl_t;
endpackage

// File: rtl/lcd_phase_divider.sv
module lcd_phase_divider
  import lcd_phase_pkg::*;
#(
  parameter int PSW  = PS_W,
  parameter int DIVW = DIV_W,
  parameter int BASE = FINE_BASE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  divCtl_t         ctl,
  input  logic [PSW-1:0]  actPs,
  input  logic [DIVW-1:0] actDiv,
  output logic            wrapTick
);
  localparam int PRE_W  = (1 << PSW) - 1;
  localparam int FINE_W = $clog2(BASE + (1 << DIVW));

  logic [PRE_W-1:0]  psCnt;
  logic [FINE_W-1:0] divCnt;
  logic [PRE_W:0]    maskFull;
  logic [PRE_W-1:0]  mask;
  logic [FINE_W-1:0] divLast;
  logic              coarseTick;

  always_comb begin
    maskFull   = ((PRE_W+1)'(1) << actPs) - (PRE_W+1)'(1);
    mask       = maskFull[PRE_W-1:0];
    divLast    = FINE_W'(BASE - 1) + FINE_W'(actDiv);
    coarseTick = ctl.run && ((psCnt & mask) == mask);
    wrapTick   = coarseTick && (divCnt == divLast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psCnt  <= '0;
      divCnt <= '0;
    end else if (ctl.clear) begin
      psCnt  <= '0;
      divCnt <= '0;
    end else if (ctl.run) begin
      psCnt <= psCnt + PRE_W'(1);
      if (coarseTick) divCnt <= wrapTick ? '0 : divCnt + FINE_W'(1);
    end
  end

  // R2: a phase lasts at least 16 cycles, so wraps never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrapTick |=> !wrapTick);

  // R3: the fine counter never passes its linear limit
  p_fine_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= divLast);
endmodule

// File: rtl/lcd_phase_sequencer.sv
module lcd_phase_sequencer
  import lcd_phase_pkg::*;
#(
  parameter int PSW   = PS_W,
  parameter int DIVW  = DIV_W,
  parameter int DUTYW = DUTY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PSW-1:0]   preScale,
  input  logic [DIVW-1:0]  fineDiv,
  input  logic [DUTYW-1:0] dutySel,
  input  logic             wrapTick,
  output divCtl_t          ctl,
  output logic [PSW-1:0]   actPs,
  output logic [DIVW-1:0]  actDiv,
  output logic             phaseTick,
  output logic [DUTYW-1:0] phaseIdx,
  output logic             frameStart,
  output logic             oddFrame
);
  logic [DUTYW-1:0] actDuty;
  logic             frameEnd;

  always_comb begin
    frameEnd  = wrapTick && (phaseIdx == actDuty);
    ctl.run   = enable;
    ctl.clear = !enable || frameEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actPs      <= '0;
      actDiv     <= '0;
      actDuty    <= '0;
      phaseTick  <= 1'b0;
      phaseIdx   <= '0;
      frameStart <= 1'b0;
      oddFrame   <= 1'b0;
    end else if (!enable) begin
      actPs      <= preScale;
      actDiv     <= fineDiv;
      actDuty    <= dutySel;
      phaseTick  <= 1'b0;
      phaseIdx   <= '0;
      frameStart <= 1'b0;
    end else begin
      phaseTick  <= wrapTick;
      frameStart <= frameEnd;
      if (frameEnd) begin
        phaseIdx <= '0;
        oddFrame <= !oddFrame;
        actPs    <= preScale;
        actDiv   <= fineDiv;
        actDuty  <= dutySel;
      end else if (wrapTick) begin
        phaseIdx <= phaseIdx + DUTYW'(1);
      end
    end
  end

  // R4: the index never leaves the active duty range
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phaseIdx <= actDuty);

  // R5: a frame start coincides with a tick at phase zero
  p_fs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (phaseTick && phaseIdx == '0));

  // R6: parity flips with each frame start
  p_odd_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (oddFrame != $past(oddFrame)));

  // R6: parity holds between frame starts
  p_odd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |-> $stable(oddFrame));

  // R7: settings stay frozen once the frame is past its first phase
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseIdx != '0) |-> ($stable(actDuty) && $stable(actPs) && $stable(actDiv)));
endmodule

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
  import lcd_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PS_W-1:0]   preScale,
  input  logic [DIV_W-1:0]  fineDiv,
  input  logic [DUTY_W-1:0] dutySel,
  output logic              phaseTick,
  output logic [DUTY_W-1:0] phaseIdx,
  output logic              frameStart,
  output logic              oddFrame
);
  divCtl_t           ctl;
  logic              wrapTick;
  logic [PS_W-1:0]   actPs;
  logic [DIV_W-1:0]  actDiv;

  lcd_phase_sequencer #(.PSW(PS_W), .DIVW(DIV_W), .DUTYW(DUTY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .preScale(preScale), .fineDiv(fineDiv), .dutySel(dutySel),
    .wrapTick(wrapTick), .ctl(ctl), .actPs(actPs), .actDiv(actDiv),
    .phaseTick(phaseTick), .phaseIdx(phaseIdx),
    .frameStart(frameStart), .oddFrame(oddFrame)
  );

  lcd_phase_divider #(.PSW(PS_W), .DIVW(DIV_W), .BASE(FINE_BASE)) u_div (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .actPs(actPs), .actDiv(actDiv), .wrapTick(wrapTick)
  );
endmodule

// File: tb/lcd_phase_timer_tb.sv
module lcd_phase_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] preScale = '0;
  logic [3:0] fineDiv = '0;
  logic [2:0] dutySel = '0;
  logic       phaseTick, frameStart, oddFrame;
  logic [2:0] phaseIdx;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state, built from the requirements
  int mCnt = 0, mIdx = 0, mPs = 0, mDiv = 0, mDuty = 0;
  bit mTick = 0, mFs = 0, mOdd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_phase_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .preScale(preScale), .fineDiv(fineDiv), .dutySel(dutySel),
    .phaseTick(phaseTick), .phaseIdx(phaseIdx),
    .frameStart(frameStart), .oddFrame(oddFrame)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mCnt = 0; mIdx = 0; mTick = 0; mFs = 0; mOdd = 0;
      mPs = 0; mDiv = 0; mDuty = 0;
    end else if (!enable) begin
      // R8: idle follows inputs and emits nothing
      mCnt = 0; mIdx = 0; mTick = 0; mFs = 0;
      mPs = preScale; mDiv = fineDiv; mDuty = dutySel;
    end else begin
      mCnt++; mTick = 0; mFs = 0;
      if (mCnt == (1 << mPs) * (16 + mDiv)) begin  // R2, R3 period
        mCnt = 0; mTick = 1;
        if (mIdx == mDuty) begin                  // R4 wrap, R5, R6, R7
          mIdx = 0; mFs = 1; mOdd = !mOdd;
          mPs = preScale; mDiv = fineDiv; mDuty = dutySel;
        end else mIdx++;
      end
    end
  end

  task automatic check1(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  task automatic compareAll();
    check1("R2 phaseTick", int'(phaseTick), int'(mTick));
    check1("R4 phaseIdx", int'(phaseIdx), mIdx);
    check1("R5 frameStart", int'(frameStart), int'(mFs));
    check1("R6 oddFrame", int'(oddFrame), int'(mOdd));
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic runConfig(input int ps, input int dv, input int dt);
    int period;
    @(negedge clk);
    enable = 1'b0; preScale = 4'(ps); fineDiv = 4'(dv); dutySel = 3'(dt);
    runCycles(2);
    enable = 1'b1;
    period = (1 << ps) * (16 + dv);
    runCycles((2 * (dt + 1) + 1) * period + 3);
  endtask

  initial begin
    int divList[3];
    int dutyList[4];
    divList = '{0, 7, 15};
    dutyList = '{0, 1, 3, 7};
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 phaseTick", int'(phaseTick), 0);
    check1("R1 phaseIdx", int'(phaseIdx), 0);
    check1("R1 frameStart", int'(frameStart), 0);
    check1("R1 oddFrame", int'(oddFrame), 0);
    rst_n = 1'b1;
    runCycles(3);

    // R2, R3, R4, R5, R6: sweep of small coarse, fine and duty settings
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 3; d++)
        for (int u = 0; u < 4; u++)
          runConfig(p, divList[d], dutyList[u]);

    // R2: a larger coarse exponent
    runConfig(5, 0, 1);

    // R7: change settings mid-frame; old frame completes unchanged
    @(negedge clk);
    enable = 1'b0; preScale = 4'd0; fineDiv = 4'd0; dutySel = 3'd3;
    runCycles(2);
    enable = 1'b1;
    runCycles(20);
    preScale = 4'd1; fineDiv = 4'd3; dutySel = 3'd1;
    runCycles(300);
    check1("R7 settled phaseIdx range", int'(phaseIdx <= 3'd1), 1);

    // R8: disable mid-frame, outputs go quiet and index clears
    dutySel = 3'd2;
    runCycles(25);
    enable = 1'b0;
    runCycles(40);
    check1("R8 idle phaseIdx", int'(phaseIdx), 0);
    check1("R8 idle phaseTick", int'(phaseTick), 0);
    enable = 1'b1;
    runCycles(4 * 38 * 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule